// File: doc/BRIEF.md
# Memory-to-Stream Tensor Reader

This block pulls one fixed-size tensor out of memory through an AXI4 read master and hands it to a downstream consumer as AXI4-Stream words, repeating the whole image as many times as software asks. The image size in bytes is fixed when the block is built. Software uses a small AXI4-Lite register set to program a buffer address and a repetition count, and then starts the run. A one-cycle completion pulse and a status bit report when the last word has left the stream port.

A build-time switch selects how the address behaves between repetitions. In increment mode each repetition reads the next consecutive buffer, so a batch of images stored back to back is streamed in order. In wrap mode every repetition rereads the same buffer from its start, which suits parameter sets that a consumer needs again for every input. The stream has the same width as the memory data bus. Reads are split into bursts that are sized to fit the internal buffer, so a stalled consumer never blocks the read data channel.

Top module: `mm2s_reader`

## Requirements
- R1: After reset, `m_arvalid`, `t_valid` and `done` are low and the control register at offset 0x0 reads 0.
- R2: The address register (offset 0x4) and the repetition register (offset 0x8) read back what was written. The control register reads bit 0 = busy and bit 1 = finished. Bit 1 is cleared by a start and set on completion.
- R3: Each repetition emits exactly IMG_BYTES/(DATA_W/8) stream words. `t_last` is high on the final word of every repetition and low on all the others.
- R4: With WRAP=0, word i of repetition r carries the memory word at address base + r*IMG_BYTES + i*(DATA_W/8), and read bursts walk those addresses in order.
- R5: With WRAP=1, every repetition reads from base onwards, so word i always carries the word at base + i*(DATA_W/8).
- R6: Each read request uses burst type INCR (`m_arburst` = 2'b01) with `m_arsize` = log2(DATA_W/8). Its length is the smallest of BURST_MAX, the words left in the current image, and the words left before the next 4 KB boundary.
- R7: While `t_valid` is high and `t_ready` is low, `t_data` and `t_last` hold steady, and no word is lost or repeated.
- R8: Read data is always accepted (`m_rready` high whenever `m_rvalid` is high). Words requested but not yet delivered on the stream never exceed FIFO_DEPTH.
- R9: `done` is high for exactly one cycle, in the cycle after the last word of the last repetition is accepted.
- R10: Writing 1 to bit 0 of offset 0x0 starts a run. Doing so while busy has no effect: the run still emits reps images and gives one `done`.
- R11: A start with a repetition count of 0 issues no reads and pulses `done` one cycle after the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | CSR_AW | Control write address |
| s_awvalid | input | 1 | Control write address valid |
| s_awready | output | 1 | Control write address ready |
| s_wdata | input | 32 | Control write data |
| s_wvalid | input | 1 | Control write data valid |
| s_wready | output | 1 | Control write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | CSR_AW | Control read address |
| s_arvalid | input | 1 | Control read address valid |
| s_arready | output | 1 | Control read address ready |
| s_rdata | output | 32 | Control read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Control read data valid |
| s_rready | input | 1 | Control read data ready |
| m_araddr | output | ADDR_W | Memory read burst address |
| m_arlen | output | 8 | Burst length minus one |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type (INCR) |
| m_arvalid | output | 1 | Read request valid |
| m_arready | input | 1 | Read request ready |
| m_rdata | input | DATA_W | Read data |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| t_data | output | DATA_W | Stream data |
| t_last | output | 1 | Last word of an image |
| t_valid | output | 1 | Stream valid |
| t_ready | input | 1 | Stream ready |
| done | output | 1 | One-cycle run completion pulse |

## Verification
A control write takes effect at the clock edge that accepts it, and its read response is available one cycle after the request. The bench therefore samples status on the falling edge that follows the accepting rising edge. The `done` pulse is due in the cycle after the final accepted stream word. For every run the bench marks the falling edge on which it sees that handshake, and it requires `done` on the next falling edge and at no other time. Stream words and read requests are checked on the falling edge before the rising edge that accepts them, against addresses and burst lengths computed from the base, the mode and the page limit. Final counts are compared only after both instances have reported completion.

// File: rtl/mm2s_reader.sv
module mm2s_reader #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int IMG_BYTES  = 4096,
  parameter int BURST_MAX  = 256,
  parameter int FIFO_DEPTH = 256,
  parameter bit WRAP       = 1'b0,
  parameter int CSR_AW     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CSR_AW-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [31:0]         s_wdata,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [CSR_AW-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [31:0]         s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [7:0]          m_arlen,
  output logic [2:0]          m_arsize,
  output logic [1:0]          m_arburst,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic                m_rvalid,
  output logic                m_rready,
  output logic [DATA_W-1:0]   t_data,
  output logic                t_last,
  output logic                t_valid,
  input  logic                t_ready,
  output logic                done
);
  localparam int BYTES  = DATA_W / 8;
  localparam int SZ     = $clog2(BYTES);
  localparam int WORDS  = IMG_BYTES / BYTES;
  localparam int WCW    = $clog2(WORDS + 1);
  localparam int FAW    = $clog2(FIFO_DEPTH);
  localparam int FCW    = $clog2(FIFO_DEPTH + 1);
  localparam int PAGE_W = 4096 / BYTES;
  localparam logic [CSR_AW-1:0] CTRL_A = CSR_AW'(0);
  localparam logic [CSR_AW-1:0] BASE_A = CSR_AW'(4);
  localparam logic [CSR_AW-1:0] REPS_A = CSR_AW'(8);

  logic              bvalid_q, rvalid_q;
  logic [31:0]       rdata_q, reps_q;
  logic [ADDR_W-1:0] base_q, run_base;
  logic              busy_q, done_q, fin_q;
  logic              iss_active, arv_q;
  logic [ADDR_W-1:0] iss_addr, araddr_q;
  logic [WCW-1:0]    iss_words, out_idx;
  logic [31:0]       iss_reps, out_reps;
  logic [7:0]        arlen_q;
  logic [FCW-1:0]    reserved;
  logic [DATA_W-1:0] mem [FIFO_DEPTH];
  logic [FAW-1:0]    wp, rp;
  logic [FCW-1:0]    cnt;
  logic [31:0]       lim_page, blen;
  logic              wr_fire, start_req, can_issue, pop, img_end;

  assign wr_fire   = s_awvalid & s_wvalid & ~bvalid_q;
  assign s_awready = s_wvalid & ~bvalid_q;
  assign s_wready  = s_awvalid & ~bvalid_q;
  assign s_bvalid  = bvalid_q;
  assign s_bresp   = 2'b00;
  assign s_arready = ~rvalid_q;
  assign s_rvalid  = rvalid_q;
  assign s_rdata   = rdata_q;
  assign s_rresp   = 2'b00;
  assign start_req = wr_fire && (s_awaddr == CTRL_A) && s_wdata[0] && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      base_q   <= '0;
      reps_q   <= '0;
    end else begin
      if (wr_fire) bvalid_q <= 1'b1;
      else if (s_bready) bvalid_q <= 1'b0;
      if (wr_fire && s_awaddr == BASE_A) base_q <= s_wdata[ADDR_W-1:0];
      if (wr_fire && s_awaddr == REPS_A) reps_q <= s_wdata;
      if (s_arvalid && !rvalid_q) begin
        rvalid_q <= 1'b1;
        case (s_araddr)
          CTRL_A:  rdata_q <= {30'd0, fin_q, busy_q};
          BASE_A:  rdata_q <= 32'(base_q);
          REPS_A:  rdata_q <= reps_q;
          default: rdata_q <= '0;
        endcase
      end else if (s_rready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  always_comb begin
    lim_page = 32'(PAGE_W) - 32'(iss_addr[11:SZ]);
    blen = 32'(BURST_MAX);
    if (32'(iss_words) < blen) blen = 32'(iss_words);
    if (lim_page < blen) blen = lim_page;
  end

  assign can_issue = iss_active && !arv_q && (32'(reserved) + blen <= 32'(FIFO_DEPTH));
  assign pop       = t_valid & t_ready;
  assign img_end   = (out_idx == WCW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      fin_q      <= 1'b0;
      run_base   <= '0;
      iss_active <= 1'b0;
      iss_addr   <= '0;
      iss_words  <= '0;
      iss_reps   <= '0;
      arv_q      <= 1'b0;
      araddr_q   <= '0;
      arlen_q    <= '0;
      out_idx    <= '0;
      out_reps   <= '0;
      reserved   <= '0;
    end else begin
      done_q   <= 1'b0;
      reserved <= reserved + (can_issue ? FCW'(blen) : FCW'(0)) - (pop ? FCW'(1) : FCW'(0));
      if (start_req) begin
        fin_q <= 1'b0;
        if (reps_q == 32'd0) begin
          done_q <= 1'b1;
          fin_q  <= 1'b1;
        end else begin
          busy_q     <= 1'b1;
          run_base   <= base_q;
          iss_active <= 1'b1;
          iss_addr   <= base_q;
          iss_words  <= WCW'(WORDS);
          iss_reps   <= reps_q;
          out_idx    <= '0;
          out_reps   <= reps_q;
        end
      end
      if (arv_q && m_arready) arv_q <= 1'b0;
      if (can_issue) begin
        arv_q     <= 1'b1;
        araddr_q  <= iss_addr;
        arlen_q   <= 8'(blen - 32'd1);
        iss_addr  <= iss_addr + (ADDR_W'(blen) << SZ);
        iss_words <= iss_words - WCW'(blen);
        if (32'(iss_words) == blen) begin
          if (iss_reps == 32'd1) begin
            iss_active <= 1'b0;
          end else begin
            iss_reps  <= iss_reps - 32'd1;
            iss_words <= WCW'(WORDS);
            if (WRAP) iss_addr <= run_base;
          end
        end
      end
      if (pop) begin
        if (img_end) begin
          out_idx <= '0;
          if (out_reps == 32'd1) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            fin_q  <= 1'b1;
          end else begin
            out_reps <= out_reps - 32'd1;
          end
        end else begin
          out_idx <= out_idx + WCW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (m_rvalid) mem[wp] <= m_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (m_rvalid) wp <= wp + FAW'(1);
      if (pop) rp <= rp + FAW'(1);
      cnt <= cnt + (m_rvalid ? FCW'(1) : FCW'(0)) - (pop ? FCW'(1) : FCW'(0));
    end
  end

  assign m_araddr  = araddr_q;
  assign m_arlen   = arlen_q;
  assign m_arsize  = 3'(SZ);
  assign m_arburst = 2'b01;
  assign m_arvalid = arv_q;
  assign m_rready  = 1'b1;
  assign t_valid   = (cnt != '0);
  assign t_data    = mem[rp];
  assign t_last    = img_end;
  assign done      = done_q;
endmodule

module mm2s_reader_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int BURST_MAX = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] m_araddr,
  input logic [7:0]        m_arlen,
  input logic [2:0]        m_arsize,
  input logic [1:0]        m_arburst,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic              m_rvalid,
  input logic              m_rready,
  input logic [DATA_W-1:0] t_data,
  input logic              t_last,
  input logic              t_valid,
  input logic              t_ready,
  input logic              done
);
  localparam int SZ = $clog2(DATA_W / 8);

  // R7
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_valid && !t_ready |=> t_valid && $stable(t_data) && $stable(t_last));

  // R6
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));

  // R6
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (32'(m_arlen) < 32'(BURST_MAX)));

  // R6
  page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (32'(m_araddr[11:0]) + ((32'(m_arlen) + 32'd1) << SZ)) <= 32'd4096);

  // R6
  burst_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (m_arburst == 2'b01) && (m_arsize == 3'(SZ)));

  // R8
  rdata_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |-> m_rready);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind mm2s_reader mm2s_reader_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_MAX(BURST_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
  .m_arvalid(m_arvalid), .m_arready(m_arready), .m_rvalid(m_rvalid), .m_rready(m_rready),
  .t_data(t_data), .t_last(t_last), .t_valid(t_valid), .t_ready(t_ready), .done(done)
);

// File: tb/mm2s_reader_bench.sv
`timescale 1ns/1ps

module mm2s_mem_model #(parameter int ADDR_W = 32, parameter int DATA_W = 32) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [7:0]        arlen,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic              rready
);
  logic              act;
  logic [ADDR_W-1:0] addr;
  logic [8:0]        left;
  assign arready = !act;
  assign rvalid  = act && !stall;
  assign rdata   = DATA_W'(addr);
  always @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; addr <= '0; left <= '0;
    end else if (!act) begin
      if (arvalid) begin
        act <= 1'b1; addr <= araddr; left <= 9'(arlen) + 9'd1;
      end
    end else if (rvalid && rready) begin
      addr <= addr + ADDR_W'(DATA_W / 8);
      left <= left - 9'd1;
      if (left == 9'd1) act <= 1'b0;
    end
  end
endmodule

module mm2s_reader_bench;
  localparam int DW = 32, AW = 32, IMG = 40, BM = 4, FD = 8, WORDS = IMG / (DW / 8);
  localparam logic [31:0] VEC [0:3][0:3] = '{
    '{32'h0000_0100, 32'd1, 32'hFF, 32'd0},
    '{32'h0000_0200, 32'd3, 32'h16, 32'd1},
    '{32'h0000_0FF8, 32'd2, 32'hFF, 32'd0},
    '{32'h0000_2FF0, 32'd3, 32'h11, 32'd1}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [3:0]  awaddr, araddr_c;
  logic        awvalid, wvalid, bready, arvalid_c, rready_c;
  logic [31:0] wdata;
  logic [7:0]  tpat;
  logic        stall_en, run_clr;
  logic [31:0] run_base, run_reps;
  int          cyc;
  wire         t_ready = tpat[0];
  wire         stall = stall_en && (cyc % 3 == 0);

  int nchk = 0, nfail = 0, wd_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  for (genvar g = 0; g < 2; g++) begin : g_dut
    logic          awready, wready, bvalid, arready_c, rvalid_c, arvalid, arready, rvalid, rready;
    logic          t_valid, t_last, done;
    logic [1:0]    bresp, rresp, arburst;
    logic [31:0]   rdata_c;
    logic [AW-1:0] araddr;
    logic [7:0]    arlen;
    logic [2:0]    arsize;
    logic [DW-1:0] rdata, t_data;

    mm2s_reader #(.ADDR_W(AW), .DATA_W(DW), .IMG_BYTES(IMG), .BURST_MAX(BM),
                  .FIFO_DEPTH(FD), .WRAP(g == 1), .CSR_AW(4)) u_mm2s_reader (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
      .s_araddr(araddr_c), .s_arvalid(arvalid_c), .s_arready(arready_c),
      .s_rdata(rdata_c), .s_rresp(rresp), .s_rvalid(rvalid_c), .s_rready(rready_c),
      .m_araddr(araddr), .m_arlen(arlen), .m_arsize(arsize), .m_arburst(arburst),
      .m_arvalid(arvalid), .m_arready(arready),
      .m_rdata(rdata), .m_rvalid(rvalid), .m_rready(rready),
      .t_data(t_data), .t_last(t_last), .t_valid(t_valid), .t_ready(t_ready), .done(done)
    );

    mm2s_mem_model #(.ADDR_W(AW), .DATA_W(DW)) u_mem (
      .clk(clk), .rst_n(rst_n), .stall(stall), .araddr(araddr), .arlen(arlen),
      .arvalid(arvalid), .arready(arready), .rdata(rdata), .rvalid(rvalid), .rready(rready)
    );

    int ridx, iidx, beats, done_cnt, issued, max_out, ar_rem, ar_cnt, elen, pg;
    int lchk = 0, lfail = 0;
    logic [31:0] exp_ar, exp_d;
    bit prev_last;

    task automatic lc(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      lchk++;
      if (!ok) begin
        lfail++;
        $display("FAIL %s (inst %0d) actual=%0h expected=%0h", req, g, act, exp);
      end
    endtask

    always @(negedge clk) begin
      if (run_clr) begin
        ridx = 0; iidx = 0; beats = 0; done_cnt = 0; issued = 0; max_out = 0;
        ar_rem = WORDS; ar_cnt = 0; exp_ar = run_base; prev_last = 0;
      end else if (rst_n) begin
        if (prev_last) lc(done == 1'b1, "R9 done after last word", 32'(done), 1);
        else if (done && run_reps != 0) lc(1'b0, "R9 done without last word", 1, 0);
        prev_last = 0;
        if (done) done_cnt++;
        if (arvalid && arready) begin
          pg = (4096 - int'(exp_ar & 32'hFFF)) / (DW / 8);
          elen = BM;
          if (ar_rem < elen) elen = ar_rem;
          if (pg < elen) elen = pg;
          lc(araddr == exp_ar, g == 0 ? "R4 burst address" : "R5 burst address", araddr, exp_ar);
          lc(int'(arlen) + 1 == elen, "R6 burst length", 32'(arlen) + 1, 32'(elen));
          exp_ar = exp_ar + (32'(arlen) + 1) * (DW / 8);
          ar_rem = ar_rem - (int'(arlen) + 1);
          issued = issued + int'(arlen) + 1;
          ar_cnt++;
          if (ar_rem <= 0) begin
            ar_rem = WORDS;
            if (g == 1) exp_ar = run_base;
          end
        end
        if (t_valid && t_ready) begin
          exp_d = run_base + 32'(iidx * (DW / 8)) + (g == 0 ? 32'(ridx * IMG) : 32'd0);
          lc(t_data == exp_d, g == 0 ? "R4 stream word" : "R5 stream word", t_data, exp_d);
          lc(t_last == (iidx == WORDS - 1), "R3 last flag", 32'(t_last), 32'(iidx == WORDS - 1));
          beats++;
          iidx++;
          if (iidx == WORDS) begin
            iidx = 0;
            ridx++;
            if (ridx == int'(run_reps)) prev_last = 1;
          end
        end
        if (issued - beats > max_out) max_out = issued - beats;
      end
    end
  end

  task automatic csr_wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    awaddr = a; wdata = d; awvalid = 1; wvalid = 1;
    @(posedge clk); #1;
    awvalid = 0; wvalid = 0;
  endtask

  task automatic csr_rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    araddr_c = a; arvalid_c = 1;
    @(posedge clk); #1;
    arvalid_c = 0;
    d = g_dut[0].rdata_c;
  endtask

  task automatic arm(input logic [31:0] b, input logic [31:0] r, input logic [7:0] p, input logic s);
    csr_wr(4'h4, b);
    csr_wr(4'h8, r);
    @(posedge clk); #1;
    run_base = b; run_reps = r; tpat = p; stall_en = s; run_clr = 1;
    @(posedge clk); #1;
    run_clr = 0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!(g_dut[0].done_cnt >= 1 && g_dut[1].done_cnt >= 1) && k < 5000) begin
      @(posedge clk); k++;
    end
    chk(k < 5000, "R9 run completes", 32'(k), 0);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             nchk + g_dut[0].lchk + g_dut[1].lchk + 1, nfail + g_dut[0].lfail + g_dut[1].lfail + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; awaddr = 0; araddr_c = 0; awvalid = 0; wvalid = 0; wdata = 0;
    arvalid_c = 0; bready = 1; rready_c = 1; tpat = 8'hFF; stall_en = 0;
    run_clr = 0; run_base = 0; run_reps = 0; cyc = 0;
    fork
      forever begin
        @(posedge clk); #1;
        tpat = {tpat[0], tpat[7:1]};
        cyc++;
      end
    join_none
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state at the ports
    chk(g_dut[0].arvalid == 0 && g_dut[1].arvalid == 0, "R1 arvalid", 32'(g_dut[0].arvalid), 0);
    chk(g_dut[0].t_valid == 0 && g_dut[1].t_valid == 0, "R1 t_valid", 32'(g_dut[0].t_valid), 0);
    chk(g_dut[0].done == 0 && g_dut[1].done == 0, "R1 done", 32'(g_dut[0].done), 0);
    @(posedge clk); #1;
    rst_n = 1;
    csr_rd(4'h0, v);
    chk(v == 0, "R1 status after reset", v, 0);

    // R2 register read-back
    csr_wr(4'h4, 32'h1234_5670);
    csr_wr(4'h8, 32'd7);
    csr_rd(4'h4, v);
    chk(v == 32'h1234_5670, "R2 base read-back", v, 32'h1234_5670);
    csr_rd(4'h8, v);
    chk(v == 32'd7, "R2 reps read-back", v, 7);

    for (int row = 0; row < 4; row++) begin
      arm(VEC[row][0], VEC[row][1], VEC[row][2][7:0], VEC[row][3][0]);
      csr_wr(4'h0, 32'd1);
      if (row == 1) begin
        repeat (3) @(posedge clk);
        csr_rd(4'h0, v);
        chk(v == 32'd1, "R2 busy during run", v, 1);
        csr_wr(4'h0, 32'd1); // R10 start while busy
      end
      wait_done();
      for (int g = 0; g < 2; g++) begin
        int b, d, m;
        b = (g == 0) ? g_dut[0].beats : g_dut[1].beats;
        d = (g == 0) ? g_dut[0].done_cnt : g_dut[1].done_cnt;
        m = (g == 0) ? g_dut[0].max_out : g_dut[1].max_out;
        chk(b == int'(VEC[row][1]) * WORDS, "R3 word count", 32'(b), VEC[row][1] * WORDS);
        chk(d == 1, row == 1 ? "R10 single done" : "R9 single done", 32'(d), 1);
        chk(m <= FD, "R8 outstanding words", 32'(m), FD);
        chk(b == int'(VEC[row][1]) * WORDS, "R7 no word lost under backpressure", 32'(b), VEC[row][1] * WORDS);
      end
      csr_rd(4'h0, v);
      chk(v == 32'd2, "R2 finished status", v, 2);
    end

    // R11 zero repetitions
    arm(32'h0000_0400, 32'd0, 8'hFF, 1'b0);
    csr_wr(4'h0, 32'd1);
    repeat (4) @(posedge clk);
    chk(g_dut[0].done_cnt == 1 && g_dut[1].done_cnt == 1, "R11 done pulse", 32'(g_dut[0].done_cnt), 1);
    chk(g_dut[0].ar_cnt == 0 && g_dut[1].ar_cnt == 0, "R11 no reads", 32'(g_dut[0].ar_cnt), 0);
    chk(g_dut[0].beats == 0, "R11 no stream words", 32'(g_dut[0].beats), 0);
    csr_rd(4'h0, v);
    chk(v == 32'd2, "R11 finished status", v, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             nchk + g_dut[0].lchk + g_dut[1].lchk, nfail + g_dut[0].lfail + g_dut[1].lfail + wd_fail);
    $finish;
  end
endmodule